// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each word of a synchronous DRAM burst. A read or write command loads a starting column. The block then presents one column per enabled clock until the burst is complete. The burst length is programmable as 1, 2, 4, 8 words or a full page. Ordering is either sequential, with a wrap inside an aligned block, or interleaved, where the low column bits are XORed with the beat index. A single-write option makes every write one word long, while reads still use the programmed length.

The mode fields are captured together with the starting column, so the command decoder may change them while a burst runs. A terminate strobe ends a burst early. A new start strobe abandons the running burst and begins a new one. When the clock-enable input is sampled low, the whole sequencer freezes.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next outputs are `col` = 0 and `active` = 0.
- R2: A start sampled with `cke` high gives `active` = 1 and `col` = `start_col` in the following cycle. The length, order and single-write fields are captured at that edge, so later changes to them do not affect the running burst.
- R3: `len_code` selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. Codes 4, 5 and 6 act as length 1. With `cke` held high and no other strobe, `active` stays high for exactly N cycles.
- R4: With `ilv_order` = 0 and length N of 8 or less, beat k has the low log2(N) bits equal to (start + k) mod N. The upper bits stay equal to the starting column.
- R5: With `ilv_order` = 1 and length 2, 4 or 8, beat k has the low log2(N) bits equal to the starting low bits XOR k. The upper bits stay fixed.
- R6: In a full-page burst, `col` steps by +1 modulo 512 every enabled cycle in both orders. The burst continues until a stop or a new start.
- R7: A stop sampled with `cke` high during a burst drops `active` in the next cycle and leaves `col` unchanged.
- R8: A start during a burst restarts the sequence from the new column. A start takes priority over a stop sampled at the same edge.
- R9: With `wr_single` = 1, a start with `is_write` = 1 gives a one-word burst. Reads still use `len_code`. With `wr_single` = 0, writes also use `len_code`.
- R10: At an edge where `cke` is sampled low, `col` and `active` do not change, and start and stop strobes are ignored.
- R11: After a burst ends, `col` keeps showing the last address that was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the sequencer |
| start | input | 1 | Loads `start_col` and begins a burst |
| stop | input | 1 | Terminates the running burst |
| is_write | input | 1 | The starting command is a write |
| start_col | input | 9 | Starting column address |
| len_code | input | 3 | Burst length code |
| ilv_order | input | 1 | 1 selects interleaved order |
| wr_single | input | 1 | 1 makes writes one word long |
| col | output | 9 | Current column address |
| active | output | 1 | A burst beat is being issued |

## Verification
Start, stop and the natural end of a burst can fall on the same edge, and a low clock enable can arrive on that same edge. Directed steps drive start together with stop, start on the final beat of a length-8 burst, and start with `cke` low. Constrained random traffic then mixes all four strobes with changing mode fields. Every cycle is compared against a bench model built from the requirements, which gives start priority over stop and lets a low enable override both.

// File: rtl/burst_seq_pkg.sv
// Package: shared constants for the burst column sequencer.
// Assumes the length code is 3 bits wide and that code 7 means full page.
package burst_seq_pkg;
    localparam int LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] LEN_1    = 3'd0;
    localparam logic [LEN_CODE_W-1:0] LEN_2    = 3'd1;
    localparam logic [LEN_CODE_W-1:0] LEN_4    = 3'd2;
    localparam logic [LEN_CODE_W-1:0] LEN_8    = 3'd3;
    localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;
endpackage

// File: rtl/burst_len_decode.sv
// Module: burst_len_decode
// Turns the length code and the write-single option into a wrap mask
// (low bits that change during the burst) and a full-page flag.
// Assumes COL_W >= 4. Unlisted codes give length 1.
module burst_len_decode
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  is_write,
    input  logic                  wr_single,
    output logic [COL_W-1:0]      wrap_mask,
    output logic                  full_page
);
    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    // Purpose: map the code to a mask, with single-word writes forced to length 1.
    always_comb begin
        wrap_mask = '0;
        full_page = 1'b0;
        if (!(is_write && wr_single)) begin
            case (len_code)
                LEN_2:    wrap_mask = COL_W'(1);
                LEN_4:    wrap_mask = COL_W'(3);
                LEN_8:    wrap_mask = COL_W'(7);
                LEN_PAGE: begin
                    wrap_mask = ALL_ONES;
                    full_page = 1'b1;
                end
                default:  wrap_mask = '0;
            endcase
        end
    end
endmodule

// File: rtl/burst_step_ctrl.sv
// Module: burst_step_ctrl
// Holds the burst state: the captured start column and mode, the beat index
// and the active flag. Assumes the inputs are synchronous to clk.
module burst_step_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] mask_in,
    input  logic             full_in,
    input  logic             ilv_in,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output logic             ilv_q,
    output logic             active_q
);
    logic last_beat;

    // Purpose: flag the final beat of a burst that is not a full page.
    always_comb last_beat = !full_q && (beat_q == mask_q);

    // Purpose: advance, restart or end the burst on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            beat_q   <= '0;
            mask_q   <= '0;
            full_q   <= 1'b0;
            ilv_q    <= 1'b0;
            active_q <= 1'b0;
        end else if (cke) begin
            if (start) begin
                base_q   <= start_col;
                beat_q   <= '0;
                mask_q   <= mask_in;
                full_q   <= full_in;
                ilv_q    <= ilv_in;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (stop || last_beat) begin
                    active_q <= 1'b0;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    // R3: the final beat with no strobe ends the burst
    a_r3_last_beat_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && active_q && last_beat && !start) |=> !active_q);

    // R7: an enabled stop without start ends the burst
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && stop && !start) |=> !active_q);
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen
// Combines the captured start column and the beat index into the current
// column. Masked bits take the sum (sequential) or the XOR (interleaved).
// The other bits keep the start value. A full page always uses the sum.
module burst_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             full_page,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic             use_xor;

    // Purpose: form the sequential sum and select the ordering.
    always_comb begin
        sum     = base + beat;
        use_xor = ilv && !full_page;
    end

    // Purpose: per-bit choice between the fixed start bit and the moving bit.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (mask[i])
                col[i] = use_xor ? (base[i] ^ beat[i]) : sum[i];
            else
                col[i] = base[i];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Column sequencer for one memory burst. It decodes the mode, keeps the burst
// state and forms the column. Assumes COL_W >= 4 and a synchronous active-low reset.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  start,
    input  logic                  stop,
    input  logic                  is_write,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  ilv_order,
    input  logic                  wr_single,
    output logic [COL_W-1:0]      col,
    output logic                  active
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] dec_mask, base_q, beat_q, mask_q;
    logic             dec_full, full_q, ilv_q;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_code),
        .is_write  (is_write),
        .wr_single (wr_single),
        .wrap_mask (dec_mask),
        .full_page (dec_full)
    );

    burst_step_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .mask_in   (dec_mask),
        .full_in   (dec_full),
        .ilv_in    (ilv_order),
        .base_q    (base_q),
        .beat_q    (beat_q),
        .mask_q    (mask_q),
        .full_q    (full_q),
        .ilv_q     (ilv_q),
        .active_q  (active)
    );

    burst_addr_gen #(.COL_W(COL_W)) u_addr (
        .base      (base_q),
        .beat      (beat_q),
        .mask      (mask_q),
        .full_page (full_q),
        .ilv       (ilv_q),
        .col       (col)
    );

    // R10: a low clock enable freezes both outputs
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col) && $stable(active)));

    // R2: an enabled start presents the start column next cycle
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (active && col == $past(start_col)));

    // R6: a full page steps by one modulo the column space
    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && active && full_q && !start && !stop) |=> (col == $past(col) + ONE));

    // R4: within a short burst the bits above the 8-word block do not move
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !($past(start) && $past(cke)) && !full_q)
        |-> (col[COL_W-1:3] == $past(col[COL_W-1:3])));

    // R11: an idle sequencer holds its column
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(cke && start)) |=> $stable(col));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1, start = 1'b0, stop = 1'b0, is_write = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       ilv_order = 1'b0, wr_single = 1'b0;
    logic [8:0] col;
    logic       active;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit done = 1'b0;

    // reference model state
    int m_base = 0, m_k = 0, m_mask = 0;
    bit m_full = 0, m_ilv = 0, m_act = 0;

    burst_col_seq i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .stop(stop),
        .is_write(is_write), .start_col(start_col), .len_code(len_code),
        .ilv_order(ilv_order), .wr_single(wr_single), .col(col), .active(active)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic int len_mask(input int code, input bit wr, input bit ws);
        if (wr && ws) return 0;
        case (code)
            1: return 1;
            2: return 3;
            3: return 7;
            7: return 511;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_col();
        int lo;
        if (m_full) return (m_base + m_k) % 512;
        if (m_ilv) lo = (m_base ^ m_k) & m_mask;
        else       lo = (m_base + m_k) & m_mask;
        return (m_base & ~m_mask & 511) | lo;
    endfunction

    // model update, from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_k = 0; m_mask = 0; m_full = 0; m_ilv = 0; m_act = 0;
        end else if (cke) begin
            if (start) begin
                m_base = start_col; m_k = 0; m_act = 1;
                m_mask = len_mask(len_code, is_write, wr_single);
                m_full = (m_mask == 511); m_ilv = ilv_order;
            end else if (m_act) begin
                if (stop) m_act = 0;
                else if (!m_full && m_k == m_mask) m_act = 0;
                else m_k = (m_k + 1) % 512;
            end
        end
    end

    task automatic check(input string tag);
        int ec;
        ec = exp_col();
        n_checks++;
        if (col !== 9'(ec) || active !== m_act) begin
            n_fail++;
            $display("FAIL %s: col=%0d active=%0d expected col=%0d active=%0d",
                     tag, col, active, ec, m_act);
        end
    endtask

    // one clock: drive, wait for the edge, sample 5 ns later
    task automatic step(input bit ck, input bit st, input bit sp, input int c,
                        input int lc, input bit il, input bit wr, input bit ws,
                        input string tag);
        cke = ck; start = st; stop = sp; start_col = 9'(c); len_code = 3'(lc);
        ilv_order = il; is_write = wr; wr_single = ws;
        @(posedge clk); #5;
        check(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset state
        rst_n = 1'b0;
        step(1, 1, 0, 77, 3, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        n_checks++;
        if (col !== 9'd0 || active !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: col=%0d active=%0d expected col=0 active=0", col, active);
        end
        #5 rst_n = 1'b1;

        // R3 every length code, sequential order
        for (int lc = 0; lc < 8; lc++) begin
            step(1, 1, 0, 9'h0A5, lc, 0, 0, 0, "R3");
            idle(9, "R3");
            if (lc == 7) step(1, 0, 1, 0, 0, 0, 0, 0, "R3");
        end
        // R4 sequential wrap within blocks of 4 and 8
        step(1, 1, 0, 9'h1F6, 2, 0, 0, 0, "R4"); idle(4, "R4");
        step(1, 1, 0, 9'h1FD, 3, 0, 0, 0, "R4"); idle(8, "R4");
        // R5 interleaved order
        step(1, 1, 0, 9'h1F5, 3, 1, 0, 0, "R5"); idle(8, "R5");
        step(1, 1, 0, 9'h013, 1, 1, 0, 0, "R5"); idle(2, "R5");
        step(1, 1, 0, 9'h0E6, 2, 1, 0, 0, "R5"); idle(4, "R5");
        // R2 mode fields change during the burst
        step(1, 1, 0, 9'h042, 2, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 7, 1, 1, 1, "R2");
        step(1, 0, 0, 0, 0, 1, 0, 0, "R2"); idle(3, "R2");
        // R6 full page wrapping past 511, interleave ignored
        step(1, 1, 0, 9'h1FC, 7, 1, 0, 0, "R6"); idle(8, "R6");
        // R7 stop, then R11 hold
        step(1, 0, 1, 0, 0, 0, 0, 0, "R7"); idle(3, "R11");
        // R8 restart in mid burst, start beats stop, start on the last beat
        step(1, 1, 0, 9'h100, 3, 0, 0, 0, "R8"); idle(2, "R8");
        step(1, 1, 0, 9'h05B, 2, 1, 0, 0, "R8");
        step(1, 1, 1, 9'h0C7, 3, 0, 0, 0, "R8"); idle(7, "R8");
        step(1, 1, 0, 9'h033, 1, 0, 0, 0, "R8"); idle(3, "R8");
        // R9 single-word writes
        step(1, 1, 0, 9'h020, 3, 0, 1, 1, "R9"); idle(3, "R9");
        step(1, 1, 0, 9'h020, 3, 0, 0, 1, "R9"); idle(8, "R9");
        step(1, 1, 0, 9'h020, 2, 0, 1, 0, "R9"); idle(4, "R9");
        // R10 freeze: start and stop while cke is low
        step(1, 1, 0, 9'h080, 3, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 9'h1AA, 1, 0, 0, 0, "R10");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R10");
        idle(8, "R10");
        step(0, 1, 0, 9'h111, 3, 0, 0, 0, "R10");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit ck, st, sp;
            string tag;
            ck = ($urandom % 100) < 85;
            st = ($urandom % 6) == 0;
            sp = ($urandom % 20) == 0;
            if (!ck) tag = "R10";
            else if (st) tag = "R8";
            else if (!m_act) tag = "R11";
            else if (m_full) tag = "R6";
            else if (m_ilv) tag = "R5";
            else tag = "R4";
            step(ck, st, sp, $urandom % 512, $urandom % 8, $urandom % 2,
                 $urandom % 2, $urandom % 2, tag);
        end
        finish_run();
    end
endmodule